// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block is the digital control core of a two-channel class-D output stage. Each channel drives its load in bridge-tied form from two half-bridges. Four PWM inputs come in, a plus and a minus input per channel. Two active-low controls come in as well: standby and mute. Fault flags arrive from analog comparators:

- an over-current flag for each half-bridge,
- one over-temperature flag,
- one supply-good flag, which already carries hysteresis.

For every half-bridge the block emits a registered two-bit gate command. The command switches on the high-side transistor, switches on the low-side transistor, or holds both off (high impedance).

The block applies several protections:

- **Mute gating and arming:** outputs are blocked while mute is low. After mute is released they stay off until every PWM input has been low in the same cycle.
- **Over-current retry:** a trip blanks only the affected half-bridge for a fixed number of cycles. The half-bridge then re-enables itself and trips again if the flag persists.
- **DC-offset detector:** it watches each channel for a continuous plus/minus disagreement and turns that channel off when the disagreement lasts too long.
- **Stuck-input watchdog:** it shuts everything down when any PWM input stays high too long while the stage is live.

An active-low summary pin reports over-current blanking, over-temperature, undervoltage and offset shutdown.

All window lengths are parameters in clock cycles. The defaults assume a 50 MHz clock:

| Window | Default cycles | Duration |
|---|---|---|
| Over-current retry | 1000 | 20 µs |
| Stuck-high limit | 10000 | 200 µs |
| Offset window | 15,000,000 | 300 ms |

Top module: `bridge_fault_supervisor`

## Requirements
- R1: While `standbyN` is low, every gate command is 00 and `faultN` is 1 one cycle later. The arming, retry, offset and stuck-high state is cleared.
- R2: While `muteN` is low, every gate command is 00 after one cycle. Once armed and free of faults, half-bridge i follows `pwmIn[i]` with one cycle of latency: input 1 gives 10 and input 0 gives 01.
- R3: After `muteN` rises, all gate commands stay 00 until a cycle in which all four PWM inputs are low. Drive begins on the second clock edge from that cycle.
- R4: A pulse on `ocFlag[i]` turns off only half-bridge i, for exactly RETRY_CYCLES cycles, and then that half-bridge resumes. If the flag is held, the half-bridge is on for one cycle at the end of each blanking window, then blanked again.
- R5: While `otFlag` is high, all gate commands are 00 after one cycle. Drive returns one cycle after the flag clears.
- R6: While `supplyGood` is low, all gate commands are 00 after one cycle. Drive returns one cycle after it is high again.
- R7: If a channel's plus and minus inputs differ for OFFSET_CYCLES consecutive cycles, that channel's two half-bridges go to 00 from the next cycle. The other channel is unaffected. The shutdown holds until the inputs agree, or until standby or mute goes low.
- R8: If any PWM input is high for HIGH_LIMIT_CYCLES consecutive cycles while standby and mute are high, `stuckHigh` goes to 1 and all gate commands go to 00 one cycle later. Both recover after that input returns low.
- R9: `faultN` is a registered output. It is 0 one cycle after any of these is present: over-current blanking, `otFlag` high, `supplyGood` low, or an offset shutdown. Otherwise it is 1. The stuck-high condition does not affect it.
- R10: The gate command of half-bridge i sits in `gateCmd[2i+1:2i]`. The value 10 means high side on, 01 means low side on, 00 means both off, and 11 never occurs. Half-bridges 0 and 1 are the plus and minus halves of channel 0; half-bridges 2 and 3 are those of channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyN | input | 1 | Active-low standby; low holds the logic in its initial state |
| muteN | input | 1 | Active-low mute; low forces all outputs off |
| pwmIn | input | 4 | PWM inputs; bit 2c is the plus input of channel c and bit 2c+1 is its minus input |
| ocFlag | input | 4 | Over-current flag per half-bridge |
| otFlag | input | 1 | Over-temperature flag |
| supplyGood | input | 1 | Supply above its operating threshold |
| gateCmd | output | 8 | Two-bit gate command per half-bridge |
| stuckHigh | output | 1 | A PWM input has been high for too long |
| faultN | output | 1 | Active-low fault summary |

## Verification
On every clock cycle, the assertions check four things:

- the gate encoding never shows 11;
- standby, mute, over-temperature and undervoltage each force all outputs off one cycle later;
- outputs stay off in the cycle right after mute is released;
- the fault summary drops after an over-temperature flag.

Only the directed scenarios can show the timed behaviour, because it depends on windows and counts:

- the exact length of the over-current blanking window and the one-cycle retry pulse when the flag is held;
- the cycle on which an alternating DC pattern shuts down only its own channel, and its recovery;
- the stuck-high limit;
- waiting for all inputs to be low before arming.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [1:0] {
    GATE_OFF  = 2'b00,
    GATE_LOW  = 2'b01,
    GATE_HIGH = 2'b10
  } gate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic driveEn;    // global permission to switch
    logic clearAll;   // standby: wipe every timer
    logic clearWatch; // standby or mute: wipe offset and stuck timers
  } strobe_t;

  // summary from datapath back to control
  typedef struct packed {
    logic anyRetry;
    logic anyOffset;
    logic anyStuck;
  } status_t;

endpackage

// File: rtl/bfs_run_timer.sv
module bfs_run_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!run) begin
      count <= '0;
    end else if (count != LIM) begin
      count <= count + 1'b1;
    end
  end

  assign done = (count == LIM);
endmodule

// File: rtl/bfs_retry_timer.sv
module bfs_retry_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic trip,
  output logic blanking
);
  localparam int W = $clog2(CYCLES + 1);
  localparam logic [W-1:0] RELOAD = W'(CYCLES);

  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (clear) begin
      remain <= '0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else if (trip) begin
      remain <= RELOAD;
    end
  end

  assign blanking = (remain != '0);
endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int NUM_CH            = 2,
  parameter int RETRY_CYCLES      = 1000,
  parameter int HIGH_LIMIT_CYCLES = 10000,
  parameter int OFFSET_CYCLES     = 15000000,
  localparam int HB               = 2 * NUM_CH
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobes,
  input  logic [HB-1:0] pwmIn,
  input  logic [HB-1:0] ocFlag,
  output logic [2*HB-1:0] gateCmd,
  output status_t       status
);

  logic [HB-1:0]     blank;
  logic [HB-1:0]     stuck;
  logic [NUM_CH-1:0] offTrip;
  gate_e             gateReg [HB];

  // per-channel DC disagreement window
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic differ;
    assign differ = (pwmIn[2*c] ^ pwmIn[2*c+1]) & ~strobes.clearWatch;
    bfs_run_timer #(.LIMIT(OFFSET_CYCLES)) u_offset (
      .clk (clk),
      .rstN(rstN),
      .run (differ),
      .done(offTrip[c])
    );
  end

  // per-half-bridge retry blanking, stuck-high watch, gate register
  for (genvar i = 0; i < HB; i++) begin : g_half
    localparam int CH = i / 2;
    logic enable;

    bfs_retry_timer #(.CYCLES(RETRY_CYCLES)) u_retry (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (strobes.clearAll),
      .trip    (ocFlag[i]),
      .blanking(blank[i])
    );

    bfs_run_timer #(.LIMIT(HIGH_LIMIT_CYCLES)) u_stuck (
      .clk (clk),
      .rstN(rstN),
      .run (pwmIn[i] & ~strobes.clearWatch),
      .done(stuck[i])
    );

    assign enable = strobes.driveEn & ~blank[i] & ~offTrip[CH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateReg[i] <= GATE_OFF;
      end else if (!enable) begin
        gateReg[i] <= GATE_OFF;
      end else begin
        gateReg[i] <= pwmIn[i] ? GATE_HIGH : GATE_LOW;
      end
    end

    assign gateCmd[2*i+1:2*i] = gateReg[i];
  end

  assign status.anyRetry  = |blank;
  assign status.anyOffset = |offTrip;
  assign status.anyStuck  = |stuck;

endmodule

// File: rtl/bfs_control.sv
module bfs_control
  import bfs_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int HB    = 2 * NUM_CH
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          standbyN,
  input  logic          muteN,
  input  logic [HB-1:0] pwmIn,
  input  logic          otFlag,
  input  logic          supplyGood,
  input  status_t       status,
  output strobe_t       strobes,
  output logic          faultN
);

  logic armed;
  logic live;
  logic faultAny;

  assign live     = standbyN & muteN;
  assign faultAny = status.anyRetry | otFlag | ~supplyGood | status.anyOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      faultN <= 1'b1;
    end else begin
      // arm only once every input has been seen low while unmuted
      armed  <= live & (armed | ~(|pwmIn));
      faultN <= ~(standbyN & faultAny);
    end
  end

  assign strobes.driveEn    = live & armed & supplyGood & ~otFlag & ~status.anyStuck;
  assign strobes.clearAll   = ~standbyN;
  assign strobes.clearWatch = ~live;

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
  import bfs_pkg::*;
#(
  parameter int NUM_CH            = 2,
  parameter int RETRY_CYCLES      = 1000,
  parameter int HIGH_LIMIT_CYCLES = 10000,
  parameter int OFFSET_CYCLES     = 15000000,
  localparam int HB               = 2 * NUM_CH
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            standbyN,
  input  logic            muteN,
  input  logic [HB-1:0]   pwmIn,
  input  logic [HB-1:0]   ocFlag,
  input  logic            otFlag,
  input  logic            supplyGood,
  output logic [2*HB-1:0] gateCmd,
  output logic            stuckHigh,
  output logic            faultN
);

  strobe_t strobes;
  status_t status;

  bfs_control #(.NUM_CH(NUM_CH)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .standbyN  (standbyN),
    .muteN     (muteN),
    .pwmIn     (pwmIn),
    .otFlag    (otFlag),
    .supplyGood(supplyGood),
    .status    (status),
    .strobes   (strobes),
    .faultN    (faultN)
  );

  bfs_datapath #(
    .NUM_CH           (NUM_CH),
    .RETRY_CYCLES     (RETRY_CYCLES),
    .HIGH_LIMIT_CYCLES(HIGH_LIMIT_CYCLES),
    .OFFSET_CYCLES    (OFFSET_CYCLES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .pwmIn  (pwmIn),
    .ocFlag (ocFlag),
    .gateCmd(gateCmd),
    .status (status)
  );

  assign stuckHigh = status.anyStuck;

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int NUM_CH = 2,
  localparam int HB    = 2 * NUM_CH
) (
  input logic            clk,
  input logic            rstN,
  input logic            standbyN,
  input logic            muteN,
  input logic            otFlag,
  input logic            supplyGood,
  input logic [2*HB-1:0] gateCmd,
  input logic            faultN
);

  for (genvar i = 0; i < HB; i++) begin : g_legal
    a_r10_no_both_on: assert property (@(posedge clk) disable iff (!rstN)
      gateCmd[2*i+1:2*i] != 2'b11);
  end

  a_r1_standby_off: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> (gateCmd == '0) && faultN);

  a_r2_mute_off: assert property (@(posedge clk) disable iff (!rstN)
    !muteN |=> gateCmd == '0);

  a_r3_hold_after_unmute: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteN) |=> gateCmd == '0);

  a_r5_thermal_off: assert property (@(posedge clk) disable iff (!rstN)
    otFlag |=> gateCmd == '0);

  a_r6_undervoltage_off: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> gateCmd == '0);

  a_r9_thermal_fault: assert property (@(posedge clk) disable iff (!rstN)
    (standbyN && otFlag) |=> !faultN);

endmodule

bind bridge_fault_supervisor bfs_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .standbyN  (standbyN),
  .muteN     (muteN),
  .otFlag    (otFlag),
  .supplyGood(supplyGood),
  .gateCmd   (gateCmd),
  .faultN    (faultN)
);

// File: tb/tb_bridge_fault_supervisor.sv
module tb_bridge_fault_supervisor;

  localparam int RETRY  = 8;
  localparam int LIMIT  = 40;
  localparam int OFFSET = 100;

  logic       clk = 1'b0;
  logic       rstN;
  logic       standbyN, muteN, otFlag, supplyGood;
  logic [3:0] pwmIn, ocFlag;
  logic [7:0] gateCmd;
  logic       stuckHigh, faultN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bridge_fault_supervisor #(
    .RETRY_CYCLES     (RETRY),
    .HIGH_LIMIT_CYCLES(LIMIT),
    .OFFSET_CYCLES    (OFFSET)
  ) dut (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .muteN(muteN),
    .pwmIn(pwmIn), .ocFlag(ocFlag), .otFlag(otFlag), .supplyGood(supplyGood),
    .gateCmd(gateCmd), .stuckHigh(stuckHigh), .faultN(faultN)
  );

  // gate codes: 01 low side, 10 high side, 00 off; all low sides = 8'h55
  localparam logic [7:0] ALL_LOW = 8'h55;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset gate", gateCmd, 0);
    chk("R1 reset faultN", faultN, 1);
  endtask

  task automatic t_arming();
    standbyN = 1; supplyGood = 1; muteN = 1; pwmIn = 4'b0001;
    tick(5);
    chk("R3 held off while an input is high", gateCmd, 0);
    pwmIn = 4'b0000;
    tick(1);
    chk("R3 still off on the arming edge", gateCmd, 0);
    tick(1);
    chk("R3 drive after all low", gateCmd, ALL_LOW);
  endtask

  task automatic t_pass();
    pwmIn = 4'b0101; tick(1);
    chk("R2 R10 pass 0101", gateCmd, 8'h66);
    pwmIn = 4'b1111; tick(1);
    chk("R2 R10 pass 1111", gateCmd, 8'hAA);
    pwmIn = 4'b1010; tick(1);
    chk("R2 R10 pass 1010", gateCmd, 8'h99);
    muteN = 0; tick(1);
    chk("R2 mute off", gateCmd, 0);
    pwmIn = 4'b0000; muteN = 1; tick(1);
    chk("R3 off right after unmute", gateCmd, 0);
    tick(1);
    chk("R2 resume after unmute", gateCmd, ALL_LOW);
  endtask

  task automatic t_overcurrent();
    ocFlag = 4'b0010; tick(1);      // trip latched on this edge
    ocFlag = 4'b0000;
    chk("R4 not yet off", gateCmd, ALL_LOW);
    tick(1);
    chk("R4 half-bridge 1 off, others on", gateCmd, 8'h51);
    chk("R9 fault on blanking", faultN, 0);
    tick(RETRY - 1);
    chk("R4 off at end of window", gateCmd, 8'h51);
    tick(1);
    chk("R4 resumes after window", gateCmd, ALL_LOW);
    chk("R9 fault clears", faultN, 1);
    ocFlag = 4'b0010; tick(1);
    tick(RETRY);
    chk("R4 held flag still blanked", gateCmd, 8'h51);
    tick(1);
    chk("R4 held flag one-cycle retry", gateCmd, ALL_LOW);
    tick(1);
    chk("R4 held flag trips again", gateCmd, 8'h51);
    ocFlag = 4'b0000;
    tick(RETRY + 2);
    chk("R4 recovered", gateCmd, ALL_LOW);
  endtask

  task automatic t_thermal();
    otFlag = 1; tick(1);
    chk("R5 thermal off", gateCmd, 0);
    chk("R9 thermal fault", faultN, 0);
    otFlag = 0; tick(1);
    chk("R5 thermal resume", gateCmd, ALL_LOW);
    chk("R9 thermal fault clears", faultN, 1);
  endtask

  task automatic t_undervoltage();
    supplyGood = 0; tick(1);
    chk("R6 undervoltage off", gateCmd, 0);
    chk("R9 undervoltage fault", faultN, 0);
    supplyGood = 1; tick(1);
    chk("R6 undervoltage resume", gateCmd, ALL_LOW);
    chk("R9 undervoltage fault clears", faultN, 1);
  endtask

  task automatic t_offset();
    for (int i = 0; i <= OFFSET; i++) begin
      pwmIn = (((i / 20) % 2) == 1) ? 4'b0010 : 4'b0001;
      tick(1);
      if (i == OFFSET - 1) begin
        chk("R7 channel 0 still on at window", gateCmd, 8'h56);
        chk("R8 alternating input not stuck", stuckHigh, 0);
      end
    end
    chk("R7 channel 0 off, channel 1 on", gateCmd, 8'h50);
    chk("R9 offset fault", faultN, 0);
    pwmIn = 4'b0000; tick(2);
    chk("R7 offset clears on agreement", gateCmd, ALL_LOW);
    chk("R9 offset fault clears", faultN, 1);
  endtask

  task automatic t_stuck();
    pwmIn = 4'b0100; tick(LIMIT);
    chk("R8 stuck flag", stuckHigh, 1);
    chk("R8 still driving on limit edge", gateCmd, 8'h65);
    tick(1);
    chk("R8 stuck forces off", gateCmd, 0);
    chk("R9 stuck not in summary", faultN, 1);
    pwmIn = 4'b0000; tick(1);
    chk("R8 stuck flag clears", stuckHigh, 0);
    tick(1);
    chk("R8 drive resumes", gateCmd, ALL_LOW);
  endtask

  task automatic t_standby();
    ocFlag = 4'b0001; tick(1);
    ocFlag = 4'b0000;
    standbyN = 0; otFlag = 1; tick(1);
    chk("R1 standby off", gateCmd, 0);
    chk("R1 standby faultN high", faultN, 1);
    otFlag = 0; standbyN = 1; tick(1);
    chk("R1 rearm needed", gateCmd, 0);
    tick(1);
    chk("R1 retry state cleared by standby", gateCmd, ALL_LOW);
    chk("R1 no fault after standby", faultN, 1);
  endtask

  initial begin
    rstN = 0; standbyN = 0; muteN = 0; otFlag = 0; supplyGood = 0;
    pwmIn = '0; ocFlag = '0;
    tick(3);
    t_reset();
    rstN = 1; tick(1);
    t_reset();
    t_arming();
    t_pass();
    t_overcurrent();
    t_thermal();
    t_undervoltage();
    t_offset();
    t_stuck();
    t_standby();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule